// File: doc/BRIEF.md
# Local Memory Controller with Selectable Wait States

This controller places a local SRAM, a small internal register file and an external general-purpose address window behind one shared local bus. Two requesters use it: a local processor port and a host slave port. Each port holds a request until the controller answers with a ready strobe. Ready rises in the last cycle of the access, and read data is valid in that same cycle. A configuration bit in the register file sets SRAM accesses to one cycle or two. Local processor register accesses follow the same setting, so the processor sees the same timing for registers and memory. Host register accesses always finish in one cycle.

When a host read to SRAM misses, the controller fetches the next four contiguous SRAM words into a small buffer. It does this in the background, at the lowest priority. A later host read that finds its word valid in the buffer is answered in one cycle and causes no SRAM access. A write into the buffered window invalidates the buffer. A host SRAM read to an address outside the buffer also invalidates it and starts a new fetch.

A mode input changes how the lower address window is used. When the input is low, a local processor is present and the window drives an external chip-select. When it is high, the controller runs standalone and the same window drives a physical-layer device select instead.

Top module: `lmem_ctrl`

## Requirements
- R1: The wait-state bit is bit 0 of the register at address 0x000. When it is 0, an SRAM access asserts ready in the first cycle of its request. When it is 1, ready is asserted in the second cycle.
- R2: After reset, the register at 0x000 reads 1 (two-cycle SRAM accesses), both ready outputs are low and no chip-select is active.
- R3: A local processor access to a register (addresses 0x000 to 0x003) takes the same number of cycles as an SRAM access with the current wait-state bit.
- R4: A host access to a register completes in the first cycle of its request, whatever the value of the wait-state bit.
- R5: A host SRAM read that misses the buffer starts a background fetch of the next four word addresses. A later host read of a buffered, valid word returns that word in the first cycle, with sram_cs low.
- R6: A write to an address inside the buffered window invalidates the whole buffer. A host SRAM read to an address that is not buffered also invalidates it. A read of a word invalidated this way uses the SRAM wait-state timing again and returns the current memory content.
- R7: Addresses 0x1FF to 0xFFF form the external window. With standalone_mode low, an access there asserts ext_cs0. With standalone_mode high, it asserts phy_cs and never ext_cs0.
- R8: When both ports request in the same idle cycle, the host is served first. The processor request stays stalled and is served after the host access completes.
- R9: A write to the wait-state bit applies to the next access that starts after the write completes.
- R10: Addresses with bit 12 set are SRAM, with the SRAM word index in bits 11:0. Addresses 0x004 to 0x1FE select nothing, read as zero and complete in one cycle. At most one chip-select is active at a time.
- R11: Read data on a port is valid in the cycle in which that port's ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standalone_mode | input | 1 | High when no local processor is present |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | 13 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data |
| cpu_rdy | output | 1 | Processor access completes this cycle |
| host_req | input | 1 | Host request, held until ready |
| host_we | input | 1 | Host write enable |
| host_addr | input | 13 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| host_rdy | output | 1 | Host access completes this cycle |
| mem_addr | output | 13 | Shared local bus address |
| mem_we | output | 1 | Shared local bus write strobe |
| mem_wdata | output | 32 | Shared local bus write data |
| mem_rdata | input | 32 | Shared local bus read data |
| sram_cs | output | 1 | SRAM select |
| ext_cs0 | output | 1 | External general-purpose select |
| phy_cs | output | 1 | Physical-layer device select (standalone) |

## Verification
The access timing is tried with register and SRAM accesses from each port under both settings of the wait-state bit. This shows that processor register timing follows the bit while host register timing does not. Host read sequences are run in three forms: contiguous after a miss, following a write into the window, and jumping to an unrelated address. Together they separate a buffer hit, an invalidation and a refetch, using both the ready cycle count and whether sram_cs was seen. Requests that arrive together show the host-first ordering. The external window is accessed in both modes to tell ext_cs0 apart from phy_cs.

// File: rtl/lmc_pkg.sv
// Shared types for the local memory controller.
// Assumes: one access is in flight on the local bus at a time.
package lmc_pkg;
    typedef enum logic [1:0] {
        RG_NONE,
        RG_REG,
        RG_SRAM,
        RG_EXT
    } region_e;

    typedef enum logic [1:0] {
        OWN_IDLE,
        OWN_HOST,
        OWN_CPU,
        OWN_PF
    } owner_e;
endpackage

// File: rtl/lmc_decode.sv
// Address decoder: sorts a word address into register, SRAM, external
// window or no target. Assumes the top address bit selects SRAM.
module lmc_decode
    import lmc_pkg::*;
#(
    parameter int AW     = 13,
    parameter int NREG   = 4,
    parameter int EXT_LO = 'h1FF
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);
    localparam logic [AW-1:0] REG_END = AW'(NREG);
    localparam logic [AW-1:0] EXT_BEG = AW'(EXT_LO);

    // classify the address
    always_comb begin
        if (addr[AW-1])
            region = RG_SRAM;
        else if (addr < REG_END)
            region = RG_REG;
        else if (addr >= EXT_BEG)
            region = RG_EXT;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/lmc_regs.sv
// Internal control registers. Word 0 bit 0 is the SRAM wait-state bit,
// reset to 1. The other words are plain storage. Assumes a single access
// port: the same index is used for read and write.
module lmc_regs #(
    parameter int DW   = 32,
    parameter int NREG = 4,
    parameter int RIW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RIW-1:0] idx,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           ws_o
);
    logic [DW-1:0] regs_q [NREG];

    // register storage with reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                regs_q[i] <= (i == 0) ? DW'(1) : '0;
        end else if (wr_en) begin
            regs_q[idx] <= wdata;
        end
    end

    // read port and wait-state bit
    assign rdata = regs_q[idx];
    assign ws_o  = regs_q[0][0];

    AST_WS_RESET: assert property (@(posedge clk) disable iff (!rst_n) !$past(rst_n) |-> ws_o) else $error("ws reset"); // R2
    AST_WS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && idx == '0) |=> ws_o == $past(wdata[0])) else $error("ws write"); // R9
endmodule

// File: rtl/lmc_prefetch.sv
// Host read prefetch buffer. A start pulse sets the window to the DEPTH
// words after the missed index and fills them in order, as the sequencer
// grants fill cycles. A write inside the window clears the buffer and stops
// the fill. Assumes start, fill_done and wr_done never occur together.
module lmc_prefetch #(
    parameter int SW    = 12,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int CW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] start_idx,
    input  logic [SW-1:0] look_idx,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    output logic          fill_req,
    output logic [SW-1:0] fill_idx,
    input  logic          fill_done,
    input  logic [DW-1:0] fill_data,
    input  logic          wr_done,
    input  logic [SW-1:0] wr_idx
);
    localparam logic [SW-1:0] DEPTH_W = SW'(DEPTH);

    logic [SW-1:0]    base_q;
    logic [DEPTH-1:0] vld_q;
    logic [CW-1:0]    cnt_q;
    logic             act_q;
    logic [DW-1:0]    buf_q [DEPTH];
    logic [SW-1:0]    look_off, wr_off;
    logic             wr_in_win;

    // window offsets for lookup and write snoop
    assign look_off  = look_idx - base_q;
    assign wr_off    = wr_idx - base_q;
    assign wr_in_win = wr_off < DEPTH_W;
    assign hit       = (look_off < DEPTH_W) && vld_q[look_off[CW-1:0]];
    assign hit_data  = buf_q[look_off[CW-1:0]];
    assign fill_req  = act_q;
    assign fill_idx  = base_q + SW'(cnt_q);

    // window, valid bits and fill pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            vld_q  <= '0;
            cnt_q  <= '0;
            act_q  <= 1'b0;
        end else if (start) begin
            base_q <= start_idx + SW'(1);
            vld_q  <= '0;
            cnt_q  <= '0;
            act_q  <= 1'b1;
        end else if (wr_done && wr_in_win) begin
            vld_q  <= '0;
            act_q  <= 1'b0;
        end else if (fill_done) begin
            vld_q[cnt_q] <= 1'b1;
            cnt_q        <= cnt_q + CW'(1);
            if (cnt_q == CW'(DEPTH - 1))
                act_q <= 1'b0;
        end
    end

    // buffer data, written in fill order
    always_ff @(posedge clk) begin
        if (fill_done && act_q)
            buf_q[cnt_q] <= fill_data;
    end

    AST_FILL_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) fill_done |-> act_q) else $error("fill idle"); // R5
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (wr_done && wr_in_win && !start) |=> (vld_q == '0 && !act_q)) else $error("no inval"); // R6
endmodule

// File: rtl/lmem_ctrl.sv
// Local memory controller top. Arbitrates host (first), processor, then
// background prefetch onto one shared local bus, sequences zero or one
// wait state, and drives the three chip-selects. Assumes each requester
// holds its request and inputs stable until its ready.
module lmem_ctrl
    import lmc_pkg::*;
#(
    parameter int AW     = 13,
    parameter int DW     = 32,
    parameter int NREG   = 4,
    parameter int PF_N   = 4,
    parameter int EXT_LO = 'h1FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standalone_mode,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rdy,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdy,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          sram_cs,
    output logic          ext_cs0,
    output logic          phy_cs
);
    localparam int SW  = AW - 1;
    localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1;

    owner_e        own_q, cur;
    logic          busy_q;
    logic [AW-1:0] cur_addr;
    logic          cur_we, active;
    logic [DW-1:0] cur_wdata, rdata, reg_rdata, pf_data;
    region_e       cur_rgn, host_rgn;
    logic          ws, need_ws, done, host_hit, pf_hit;
    logic          pf_req, pf_done, pf_start, sram_wr_done;
    logic [SW-1:0] pf_idx;

    // pick the owner: a locked access first, then host, processor, prefetch
    always_comb begin
        if (busy_q)        cur = own_q;
        else if (host_req) cur = OWN_HOST;
        else if (cpu_req)  cur = OWN_CPU;
        else if (pf_req)   cur = OWN_PF;
        else               cur = OWN_IDLE;
    end

    // route the owner's request onto the local bus
    always_comb begin
        unique case (cur)
            OWN_HOST: begin cur_addr = host_addr; cur_we = host_we; cur_wdata = host_wdata; end
            OWN_CPU:  begin cur_addr = cpu_addr;  cur_we = cpu_we;  cur_wdata = cpu_wdata;  end
            OWN_PF:   begin cur_addr = {1'b1, pf_idx}; cur_we = 1'b0; cur_wdata = '0; end
            default:  begin cur_addr = '0; cur_we = 1'b0; cur_wdata = '0; end
        endcase
    end

    lmc_decode #(.AW(AW), .NREG(NREG), .EXT_LO(EXT_LO)) u_dec_cur (
        .addr(cur_addr), .region(cur_rgn)
    );
    lmc_decode #(.AW(AW), .NREG(NREG), .EXT_LO(EXT_LO)) u_dec_host (
        .addr(host_addr), .region(host_rgn)
    );

    assign active   = (cur != OWN_IDLE);
    assign host_hit = (cur == OWN_HOST) && !cur_we && (cur_rgn == RG_SRAM) && pf_hit;

    // wait-state need: SRAM misses and processor register accesses
    always_comb begin
        unique case (cur_rgn)
            RG_SRAM: need_ws = ws && !host_hit;
            RG_REG:  need_ws = ws && (cur == OWN_CPU);
            default: need_ws = 1'b0;
        endcase
    end

    assign done = active && (busy_q || !need_ws);

    // wait-state sequencer: lock the owner for the second cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            own_q  <= OWN_IDLE;
        end else if (busy_q) begin
            busy_q <= 1'b0;
            own_q  <= OWN_IDLE;
        end else if (active && need_ws) begin
            busy_q <= 1'b1;
            own_q  <= cur;
        end
    end

    // chip-selects and shared bus
    assign sram_cs   = active && (cur_rgn == RG_SRAM) && !host_hit;
    assign ext_cs0   = active && (cur_rgn == RG_EXT) && !standalone_mode;
    assign phy_cs    = active && (cur_rgn == RG_EXT) && standalone_mode;
    assign mem_addr  = cur_addr;
    assign mem_we    = cur_we && (sram_cs || ext_cs0 || phy_cs);
    assign mem_wdata = cur_wdata;

    lmc_regs #(.DW(DW), .NREG(NREG), .RIW(RIW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(done && cur_we && (cur_rgn == RG_REG)),
        .idx(cur_addr[RIW-1:0]), .wdata(cur_wdata),
        .rdata(reg_rdata), .ws_o(ws)
    );

    // read data source
    always_comb begin
        if (host_hit)                                      rdata = pf_data;
        else if (cur_rgn == RG_SRAM || cur_rgn == RG_EXT)  rdata = mem_rdata;
        else if (cur_rgn == RG_REG)                        rdata = reg_rdata;
        else                                               rdata = '0;
    end

    assign cpu_rdy      = done && (cur == OWN_CPU);
    assign host_rdy     = done && (cur == OWN_HOST);
    assign cpu_rdata    = rdata;
    assign host_rdata   = rdata;
    assign pf_done      = done && (cur == OWN_PF);
    assign pf_start     = host_rdy && !cur_we && (cur_rgn == RG_SRAM) && !host_hit;
    assign sram_wr_done = done && cur_we && (cur_rgn == RG_SRAM);

    lmc_prefetch #(.SW(SW), .DW(DW), .DEPTH(PF_N)) u_pf (
        .clk(clk), .rst_n(rst_n),
        .start(pf_start), .start_idx(cur_addr[SW-1:0]),
        .look_idx(host_addr[SW-1:0]), .hit(pf_hit), .hit_data(pf_data),
        .fill_req(pf_req), .fill_idx(pf_idx),
        .fill_done(pf_done), .fill_data(mem_rdata),
        .wr_done(sram_wr_done), .wr_idx(cur_addr[SW-1:0])
    );

    AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n) (host_req && cpu_req && !busy_q) |-> !cpu_rdy) else $error("cpu won"); // R8
    AST_HOST_REG_ZW: assert property (@(posedge clk) disable iff (!rst_n) (host_req && !busy_q && host_rgn == RG_REG) |-> host_rdy) else $error("host reg wait"); // R4
    AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({sram_cs, ext_cs0, phy_cs})) else $error("cs overlap"); // R10
    AST_CS0_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) standalone_mode |-> !ext_cs0) else $error("cs0 standalone"); // R7
    AST_HIT_NO_SRAM: assert property (@(posedge clk) disable iff (!rst_n) (host_rdy && !busy_q && pf_hit && !host_we && host_rgn == RG_SRAM) |-> !sram_cs) else $error("hit used sram"); // R5
    AST_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> (cpu_rdy || host_rdy || pf_done)) else $error("wait overrun"); // R1
    AST_WAIT_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> $stable(mem_addr)) else $error("bus moved"); // R11
endmodule

// File: tb/lmem_ctrl_tb.sv
// Scoreboard bench: driver tasks push expected results, a monitor pops
// and compares them when a ready appears.
module lmem_ctrl_tb;
    localparam int AW = 13;
    localparam int DW = 32;
    localparam logic [DW-1:0] EXT_VAL = 32'h0E0E_0001;
    localparam logic [DW-1:0] PHY_VAL = 32'h0B0B_0002;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standalone_mode = 1'b0;
    logic cpu_req = 0, cpu_we = 0, host_req = 0, host_we = 0;
    logic [AW-1:0] cpu_addr = '0, host_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, host_wdata = '0;
    logic [DW-1:0] cpu_rdata, host_rdata, mem_wdata, mem_rdata;
    logic cpu_rdy, host_rdy, mem_we, sram_cs, ext_cs0, phy_cs;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] sram_model [4096];

    int total = 0, bad = 0, sram_cyc = 0, hcnt = 0, ccnt = 0;
    bit seen_cs0 = 0, seen_phy = 0;

    typedef struct {
        logic [DW-1:0] data;
        int            cyc;
        bit            chk_data;
        string         tag;
    } exp_t;
    exp_t hq[$], cq[$];

    always #2 clk = ~clk;

    lmem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .standalone_mode(standalone_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdy(host_rdy),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sram_cs(sram_cs), .ext_cs0(ext_cs0), .phy_cs(phy_cs)
    );

    // bus-side models: asynchronous SRAM read, fixed external values
    assign mem_rdata = sram_cs ? sram_model[mem_addr[11:0]] :
                       ext_cs0 ? EXT_VAL : (phy_cs ? PHY_VAL : '0);
    always @(posedge clk) if (sram_cs && mem_we) sram_model[mem_addr[11:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: count request cycles, compare on ready
    initial forever begin
        @(negedge clk); #1;
        if (sram_cs) sram_cyc++;
        if (ext_cs0) seen_cs0 = 1;
        if (phy_cs)  seen_phy = 1;
        if (host_req) hcnt++;
        if (cpu_req)  ccnt++;
        if (host_rdy) begin
            exp_t e;
            if (hq.size() == 0) chk(0, "R11", "host ready unexpected", 1, 0);
            else begin
                e = hq.pop_front();
                chk(hcnt == e.cyc, e.tag, "host cycles", hcnt, e.cyc);
                if (e.chk_data) chk(host_rdata == e.data, e.tag, "host data", host_rdata, e.data);
            end
            hcnt = 0;
        end
        if (cpu_rdy) begin
            exp_t e;
            if (cq.size() == 0) chk(0, "R11", "cpu ready unexpected", 1, 0);
            else begin
                e = cq.pop_front();
                chk(ccnt == e.cyc, e.tag, "cpu cycles", ccnt, e.cyc);
                if (e.chk_data) chk(cpu_rdata == e.data, e.tag, "cpu data", cpu_rdata, e.data);
            end
            ccnt = 0;
        end
    end

    // drivers: called at a falling edge, return at a falling edge
    task automatic hacc(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] exp, input int cyc, input bit cd, input string tag);
        bit r;
        hq.push_back('{exp, cyc, cd, tag});
        host_req = 1; host_we = we; host_addr = a; host_wdata = d;
        do begin #1; r = host_rdy; @(negedge clk); end while (!r);
        host_req = 0; host_we = 0;
    endtask

    task automatic cacc(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] exp, input int cyc, input bit cd, input string tag);
        bit r;
        cq.push_back('{exp, cyc, cd, tag});
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do begin #1; r = cpu_rdy; @(negedge clk); end while (!r);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "R11", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(!host_rdy && !cpu_rdy, "R2", "ready after reset", {host_rdy, cpu_rdy}, 0);
        chk(!sram_cs && !ext_cs0 && !phy_cs, "R2", "cs after reset", {sram_cs, ext_cs0, phy_cs}, 0);
        @(negedge clk);
        // register timing under the default wait state
        cacc(0, 13'h000, 0, 1, 2, 1, "R2 R3 cpu reg default");
        hacc(0, 13'h000, 0, 1, 1, 1, "R4 host reg default");
        for (int i = 0; i < 8; i++)
            cacc(1, 13'h1010 + 13'(i), 32'hA000_0000 + i, 0, 2, 0, "R1 cpu sram write ws1");
        cacc(0, 13'h1012, 0, 32'hA000_0002, 2, 1, "R1 R11 cpu sram read ws1");
        // zero wait states
        hacc(1, 13'h000, 0, 0, 1, 0, "R4 host reg write");
        cacc(0, 13'h1013, 0, 32'hA000_0003, 1, 1, "R1 cpu sram read ws0");
        cacc(0, 13'h000, 0, 0, 1, 1, "R3 cpu reg ws0");
        hacc(0, 13'h001, 0, 0, 1, 1, "R4 host reg ws0");
        cacc(1, 13'h000, 1, 0, 1, 0, "R9 ws write takes old timing");
        cacc(0, 13'h1014, 0, 32'hA000_0004, 2, 1, "R9 next access uses new ws");
        // prefetch hits
        hacc(0, 13'h1010, 0, 32'hA000_0000, 2, 1, "R5 host miss");
        idle(12);
        s0 = sram_cyc;
        hacc(0, 13'h1011, 0, 32'hA000_0001, 1, 1, "R5 first buffered word");
        hacc(0, 13'h1014, 0, 32'hA000_0004, 1, 1, "R5 last buffered word");
        chk(sram_cyc == s0, "R5", "sram cs during hits", sram_cyc, s0);
        // invalidation
        cacc(1, 13'h1012, 32'hBEEF_0012, 0, 2, 0, "R6 write into window");
        hacc(0, 13'h1012, 0, 32'hBEEF_0012, 2, 1, "R6 read after write");
        idle(12);
        hacc(0, 13'h1016, 0, 32'hA000_0006, 1, 1, "R5 refetched window");
        hacc(0, 13'h1030, 0, 0, 2, 0, "R6 non-contiguous miss");
        idle(12);
        hacc(0, 13'h1013, 0, 32'hA000_0003, 2, 1, "R6 old window dropped");
        idle(12);
        // external window in both modes
        seen_cs0 = 0; seen_phy = 0;
        cacc(0, 13'h0200, 0, EXT_VAL, 1, 1, "R7 ext read cs0");
        chk(seen_cs0 && !seen_phy, "R7", "cs0 in processor mode", {seen_cs0, seen_phy}, 2'b10);
        standalone_mode = 1; seen_cs0 = 0; seen_phy = 0;
        cacc(1, 13'h01FF, 32'h1, 0, 1, 0, "R7 standalone write");
        hacc(0, 13'h0FFF, 0, PHY_VAL, 1, 1, "R7 standalone read");
        chk(seen_phy && !seen_cs0, "R7", "phy select standalone", {seen_cs0, seen_phy}, 2'b01);
        standalone_mode = 0; seen_cs0 = 0; seen_phy = 0; s0 = sram_cyc;
        hacc(0, 13'h01FE, 0, 0, 1, 1, "R10 unmapped host");
        cacc(0, 13'h0004, 0, 0, 1, 1, "R10 unmapped cpu");
        chk(!seen_cs0 && !seen_phy && sram_cyc == s0, "R10", "no select unmapped",
            {seen_cs0, seen_phy}, 0);
        // simultaneous requests
        fork
            hacc(0, 13'h1010, 0, 32'hA000_0000, 2, 1, "R8 host first");
            cacc(0, 13'h1015, 0, 32'hA000_0005, 4, 1, "R8 cpu stalled");
        join
        idle(12);
        chk(hq.size() == 0 && cq.size() == 0, "R11", "pending items", hq.size() + cq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule